// File: doc/BRIEF.md
# Three-Level Hardware Page Table Walker

This block resolves a TLB miss by reading a three-level page table out of memory. A miss arrives as a 33-bit virtual page number together with the physical base address of the top-level table. The walker then reads one 4-byte page table entry per level through a single-request memory port. It ends in one of three ways: a refill record for a 2KB page, a refill record for a 16MB superpage, or a fault code. Virtual addresses are 44 bits wide and physical addresses are 36 bits wide.

The levels index unequal slices of the page number. The top and middle tables take 10 bits each and hold 1024 entries each. The bottom table takes the low 13 bits and holds 8192 entries. A walk that meets a leaf in the middle table stops there and yields a 16MB mapping, whose offset spans 24 bits.

Each entry has the following layout:

| Bits | Meaning |
|------|---------|
| 0 | valid |
| 1 | leaf |
| 26:2 | 25-bit physical page number, counted in 2KB units |
| 31:27 | ignored |

The address of an entry is the table base plus four times the index. A non-leaf entry gives the base of the next table, which is its page number shifted left by 11.

The controller has four states:

| State | Role |
|-------|------|
| IDLE | Accepts a miss. Moves to ISSUE. |
| ISSUE | Presents the entry read. Moves to AWAIT when the read is accepted. |
| AWAIT | Waits for the read data. Returns to ISSUE when the entry points to a deeper table. Moves to REPORT on a leaf or a fault. |
| REPORT | Shows the result for one cycle, then returns to IDLE. |

Top module: `ptw_three_level`

## Requirements
- R1: After reset, `miss_ready` is 1 and both `mem_req_valid` and `fill_valid` are 0.
- R2: The first read of a walk goes to `root_ptr + 4*vpn[32:23]`, modulo 2^36.
- R3: The second read goes to `(ppn1<<11) + 4*vpn[22:13]` and the third read goes to `(ppn2<<11) + 4*vpn[12:0]`. Here ppnN is the page number of the non-leaf entry read at level N.
- R4: A valid leaf at level 3 ends the walk with `fill_fault`=0, `fill_super`=0, `fill_ppn` set to that entry's page number and `fill_tag` set to the full VPN.
- R5: A valid leaf at level 2 whose page number has its low 13 bits at zero ends the walk after two reads. The result has `fill_super`=1, `fill_fault`=0, `fill_ppn` set to the entry's page number and `fill_tag` set to the VPN with its low 13 bits cleared.
- R6: A level-2 leaf whose page number has any of its low 13 bits set ends the walk with `fill_fault`=2 (misaligned superpage).
- R7: An entry with valid=0 at any level ends the walk at once with `fill_fault`=1. A valid non-leaf entry at level 3 also gives `fill_fault`=1. In both cases `fill_tag` carries the full VPN.
- R8: A valid leaf at level 1 ends the walk after one read with `fill_fault`=3.
- R9: At most one memory read is outstanding. An unaccepted request keeps `mem_req_valid` high and `mem_req_addr` stable.
- R10: `fill_valid` is a one-cycle pulse. Any fault result carries `fill_super`=0 and `fill_ppn`=0. `miss_ready` is low from the cycle after a miss is accepted until the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | A miss request is present |
| miss_ready | output | 1 | Walker is idle and takes the miss |
| miss_vpn | input | 33 | Virtual page number to translate |
| root_ptr | input | 36 | Physical base address of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Page table entry returned |
| fill_valid | output | 1 | Result pulse |
| fill_fault | output | 2 | Fault code: 0 none, 1 invalid or missing leaf, 2 misaligned superpage, 3 leaf at level 1 |
| fill_super | output | 1 | 1 for a 16MB mapping |
| fill_tag | output | 33 | VPN tag for the refill |
| fill_ppn | output | 25 | Physical page number in 2KB units |

## Verification
The assertions check the following properties on every cycle:
- A second read is never issued while one is outstanding.
- A stalled request holds its address.
- The result pulse lasts one cycle.
- Superpage results are aligned.
- Fault results carry no mapping.

Only the bench scenarios can show the rest. This covers the entry address at each level, including wrap-around of the 36-bit sum. It also covers choosing the right result and fault code for each kind of entry, the number of reads a walk makes, and the tag masking for superpages. The bench reaches these through random walks with random memory stalls and through directed edge cases.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_AWAIT  = 2'd2,
        ST_REPORT = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_INVALID   = 2'd1,
        FLT_MISALIGN  = 2'd2,
        FLT_ROOT_LEAF = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        DEC_DESCEND    = 2'd0,
        DEC_LEAF_SMALL = 2'd1,
        DEC_LEAF_SUPER = 2'd2,
        DEC_FAULT      = 2'd3
    } decode_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VPN_W   = 33,
    parameter int PA_W    = 36,
    parameter int L1_BITS = 10,
    parameter int L2_BITS = 10,
    parameter int L3_BITS = 13,
    parameter int PTE_W   = 32
) (
    input  logic [1:0]       level,
    input  logic [VPN_W-1:0] vpn,
    input  logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  addr
);
    localparam int PTE_LOG = $clog2(PTE_W / 8);

    logic [PA_W-1:0] idx;

    // Each level takes its own slice of the page number, top slice first.
    always_comb begin
        unique case (level)
            2'd0:    idx = PA_W'(vpn[VPN_W-1 -: L1_BITS]);
            2'd1:    idx = PA_W'(vpn[L3_BITS +: L2_BITS]);
            default: idx = PA_W'(vpn[L3_BITS-1:0]);
        endcase
        addr = base + (idx << PTE_LOG);
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int PTE_W       = 32,
    parameter int PPN_W       = 25,
    parameter int ALIGN_BITS  = 13,
    parameter int LAST_LEVEL  = 2
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       level,
    output decode_e          kind,
    output fault_e           fault,
    output logic [PPN_W-1:0] ppn
);
    localparam int VALID_BIT = 0;
    localparam int LEAF_BIT  = 1;
    localparam int PPN_LSB   = 2;

    logic unused_hi;
    assign unused_hi = ^pte[PTE_W-1:PPN_LSB+PPN_W];

    always_comb begin
        ppn   = pte[PPN_LSB +: PPN_W];
        kind  = DEC_FAULT;
        fault = FLT_INVALID;
        if (!pte[VALID_BIT]) begin
            kind  = DEC_FAULT;
            fault = FLT_INVALID;
        end else if (!pte[LEAF_BIT]) begin
            if (level == 2'(LAST_LEVEL)) begin
                kind  = DEC_FAULT;
                fault = FLT_INVALID;
            end else begin
                kind  = DEC_DESCEND;
                fault = FLT_NONE;
            end
        end else begin
            unique case (level)
                2'd0: begin
                    kind  = DEC_FAULT;
                    fault = FLT_ROOT_LEAF;
                end
                2'd1: begin
                    if (|ppn[ALIGN_BITS-1:0]) begin
                        kind  = DEC_FAULT;
                        fault = FLT_MISALIGN;
                    end else begin
                        kind  = DEC_LEAF_SUPER;
                        fault = FLT_NONE;
                    end
                end
                default: begin
                    kind  = DEC_LEAF_SMALL;
                    fault = FLT_NONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ptw_three_level.sv
module ptw_three_level
    import ptw_pkg::*;
#(
    parameter int VA_W     = 44,
    parameter int PA_W     = 36,
    parameter int PAGE_OFS = 11,
    parameter int L1_BITS  = 10,
    parameter int L2_BITS  = 10,
    parameter int L3_BITS  = 13,
    parameter int PTE_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       miss_valid,
    output logic                       miss_ready,
    input  logic [VA_W-PAGE_OFS-1:0]   miss_vpn,
    input  logic [PA_W-1:0]            root_ptr,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic [PA_W-1:0]            mem_req_addr,
    input  logic                       mem_rsp_valid,
    input  logic [PTE_W-1:0]           mem_rsp_data,
    output logic                       fill_valid,
    output logic [1:0]                 fill_fault,
    output logic                       fill_super,
    output logic [VA_W-PAGE_OFS-1:0]   fill_tag,
    output logic [PA_W-PAGE_OFS-1:0]   fill_ppn
);
    localparam int VPN_W = VA_W - PAGE_OFS;
    localparam int PPN_W = PA_W - PAGE_OFS;

    walk_state_e       state_q, state_d;
    logic [VPN_W-1:0]  vpn_q;
    logic [PA_W-1:0]   base_q;
    logic [1:0]        lvl_q;
    fault_e            fault_q;
    logic              super_q;
    logic [PPN_W-1:0]  ppn_q;

    logic [PA_W-1:0]   pte_addr;
    decode_e           dec_kind;
    fault_e            dec_fault;
    logic [PPN_W-1:0]  dec_ppn;

    ptw_addr_gen #(
        .VPN_W(VPN_W), .PA_W(PA_W), .L1_BITS(L1_BITS),
        .L2_BITS(L2_BITS), .L3_BITS(L3_BITS), .PTE_W(PTE_W)
    ) addr_gen_i (
        .level(lvl_q), .vpn(vpn_q), .base(base_q), .addr(pte_addr)
    );

    ptw_pte_decode #(
        .PTE_W(PTE_W), .PPN_W(PPN_W), .ALIGN_BITS(L3_BITS), .LAST_LEVEL(2)
    ) pte_decode_i (
        .pte(mem_rsp_data), .level(lvl_q),
        .kind(dec_kind), .fault(dec_fault), .ppn(dec_ppn)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (miss_valid)    state_d = ST_ISSUE;
            ST_ISSUE:  if (mem_req_ready) state_d = ST_AWAIT;
            ST_AWAIT:  if (mem_rsp_valid)
                           state_d = (dec_kind == DEC_DESCEND) ? ST_ISSUE : ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            base_q  <= '0;
            lvl_q   <= '0;
            fault_q <= FLT_NONE;
            super_q <= 1'b0;
            ppn_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && miss_valid) begin
                vpn_q   <= miss_vpn;
                base_q  <= root_ptr;
                lvl_q   <= '0;
                fault_q <= FLT_NONE;
                super_q <= 1'b0;
                ppn_q   <= '0;
            end
            if (state_q == ST_AWAIT && mem_rsp_valid) begin
                unique case (dec_kind)
                    DEC_DESCEND: begin
                        base_q <= {dec_ppn, {PAGE_OFS{1'b0}}};
                        lvl_q  <= lvl_q + 2'd1;
                    end
                    DEC_LEAF_SMALL: ppn_q <= dec_ppn;
                    DEC_LEAF_SUPER: begin
                        ppn_q   <= dec_ppn;
                        super_q <= 1'b1;
                    end
                    default: fault_q <= dec_fault;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        miss_ready    = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = pte_addr;
        fill_valid    = (state_q == ST_REPORT);
        fill_fault    = fault_q;
        fill_super    = super_q;
        fill_ppn      = ppn_q;
        fill_tag      = super_q ? {vpn_q[VPN_W-1:L3_BITS], {L3_BITS{1'b0}}} : vpn_q;
    end

    // Outstanding-read tracker used by the checks below
    logic req_pending;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              req_pending <= 1'b0;
        else if (mem_req_valid && mem_req_ready) req_pending <= 1'b1;
        else if (mem_rsp_valid)                  req_pending <= 1'b0;
    end

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_pending |-> !mem_req_valid);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_fill_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    assert_fault_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_fault != 2'd0) |-> (!fill_super && fill_ppn == '0));

    assert_super_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_super) |->
            (fill_fault == 2'd0 && fill_ppn[L3_BITS-1:0] == '0 && fill_tag[L3_BITS-1:0] == '0));

endmodule

// File: tb/ptw_three_level_tb_top.sv
module ptw_three_level_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid, miss_ready;
    logic [32:0] miss_vpn;
    logic [35:0] root_ptr;
    logic        mem_req_valid, mem_req_ready;
    logic [35:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        fill_valid, fill_super;
    logic [1:0]  fill_fault;
    logic [32:0] fill_tag;
    logic [24:0] fill_ppn;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ptw_three_level dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vpn(miss_vpn), .root_ptr(root_ptr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_super(fill_super),
        .fill_tag(fill_tag), .fill_ppn(fill_ppn)
    );

    task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model of one walk, built from the requirements
    task automatic predict(input logic [32:0] vpn, input logic [35:0] root,
                           input logic [31:0] p [3],
                           output logic [35:0] ea [3], output int nreq,
                           output logic [1:0] flt, output logic sup,
                           output logic [24:0] ppn, output logic [32:0] tag);
        logic [35:0] base;
        logic [35:0] idx;
        base = root; nreq = 0; flt = 2'd0; sup = 1'b0; ppn = '0; tag = vpn;
        for (int k = 0; k < 3; k++) ea[k] = '0;
        for (int l = 0; l < 3; l++) begin
            idx = (l == 0) ? 36'(vpn[32:23]) : (l == 1) ? 36'(vpn[22:13]) : 36'(vpn[12:0]);
            ea[l] = base + (idx << 2);
            nreq  = l + 1;
            if (!p[l][0]) begin flt = 2'd1; break; end
            if (p[l][1]) begin
                if (l == 0) flt = 2'd3;
                else if (l == 1) begin
                    if (p[l][14:2] != 13'd0) flt = 2'd2;
                    else begin
                        sup = 1'b1; ppn = p[l][26:2]; tag = {vpn[32:13], 13'd0};
                    end
                end else ppn = p[l][26:2];
                break;
            end
            if (l == 2) begin flt = 2'd1; break; end
            base = {p[l][26:2], 11'd0};
        end
    endtask

    function automatic logic [31:0] mk_pte(logic v, logic leaf, logic [24:0] ppn);
        logic [4:0] junk;
        junk = 5'($urandom);
        return {junk, ppn, leaf, v};
    endfunction

    task automatic run_walk(input logic [32:0] vpn, input logic [35:0] root,
                            input logic [31:0] p [3], input bit stalls);
        logic [35:0] ea [3];
        int          nexp, nreq;
        logic [1:0]  eflt;
        logic        esup;
        logic [24:0] eppn;
        logic [32:0] etag;
        logic [35:0] held;
        bit          done;
        int          guard;
        predict(vpn, root, p, ea, nexp, eflt, esup, eppn, etag);
        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = vpn; root_ptr = root;
        @(negedge clk);
        miss_valid = 1'b0;
        check_eq("R10", "miss_ready during walk", miss_ready, 0);
        nreq = 0; done = 0; guard = 0;
        while (!done && guard < 100) begin
            guard++;
            if (fill_valid) begin
                done = 1;
                check_eq("R2/R3", "read count", nreq, nexp);
                check_eq("R6 R7 R8", "fault code", fill_fault, eflt);
                check_eq("R4 R5", "super flag", fill_super, esup);
                check_eq("R4 R5 R10", "ppn", fill_ppn, eppn);
                check_eq("R4 R5 R7", "tag", fill_tag, etag);
                @(negedge clk);
                check_eq("R10", "fill pulse width", fill_valid, 0);
                check_eq("R10", "ready after fill", miss_ready, 1);
            end else if (mem_req_valid) begin
                if (nreq < 3)
                    check_eq(nreq == 0 ? "R2" : "R3", "read address", mem_req_addr, ea[nreq]);
                else
                    check_eq("R9", "extra read", nreq, nexp);
                held = mem_req_addr;
                if (stalls) begin
                    repeat ($urandom % 3) begin
                        @(negedge clk);
                        check_eq("R9", "held request", {mem_req_valid, mem_req_addr}, {1'b1, held});
                    end
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                check_eq("R9", "no second read", mem_req_valid, 0);
                if (stalls) repeat ($urandom % 3) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = (nreq < 3) ? p[nreq] : 32'd0;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                nreq++;
            end else @(negedge clk);
        end
        if (!done) check_eq("R10", "walk completed", 0, 1);
    endtask

    task automatic random_walk(int kind);
        logic [31:0] p [3];
        logic [32:0] vpn;
        logic [35:0] root;
        logic [24:0] r0, r1, r2;
        int          bad;
        vpn  = {1'($urandom), 32'($urandom)};
        root = {4'($urandom), 32'($urandom)};
        r0 = 25'($urandom); r1 = 25'($urandom); r2 = 25'($urandom);
        p[0] = mk_pte(1, 0, r0); p[1] = mk_pte(1, 0, r1); p[2] = mk_pte(1, 1, r2);
        unique case (kind)
            0: ;
            1: p[1] = mk_pte(1, 1, {r1[24:13], 13'd0});
            2: p[1] = mk_pte(1, 1, {r1[24:13], r1[12:1], 1'b1});
            3: begin bad = $urandom % 3; p[bad] = mk_pte(0, 1'($urandom), r2); end
            4: p[0] = mk_pte(1, 1, r0);
            default: p[2] = mk_pte(1, 0, r2);
        endcase
        run_walk(vpn, root, p, 1);
    endtask

    initial begin
        logic [31:0] p [3];
        void'($urandom(32'd20240611));
        rst_n = 1'b0; miss_valid = 0; miss_vpn = '0; root_ptr = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        check_eq("R1", "reset miss_ready", miss_ready, 1);
        check_eq("R1", "reset mem_req_valid", mem_req_valid, 0);
        check_eq("R1", "reset fill_valid", fill_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 small page, all-zero VPN, no stalls
        p[0] = {5'd0, 25'h10, 2'b01}; p[1] = {5'd0, 25'h20, 2'b01}; p[2] = {5'd0, 25'h1ABCDE, 2'b11};
        run_walk(33'd0, 36'h0_0000_1000, p, 0);
        // R2 address wrap at 36 bits, all-ones VPN
        p[0] = {5'h1F, 25'h1FFFFFF, 2'b01}; p[1] = {5'h1F, 25'h1FFFFFF, 2'b01}; p[2] = {5'h1F, 25'h1FFFFFF, 2'b11};
        run_walk({33{1'b1}}, 36'hF_FFFF_FFFC, p, 0);
        // R5 largest aligned superpage
        p[1] = {5'd0, 25'h1FFE000, 2'b11};
        run_walk(33'h1_2345_6789, 36'h0_8000_0000, p, 1);
        // R6 misaligned by lowest bit only
        p[1] = {5'd0, 25'h0002001, 2'b11};
        run_walk(33'h0_00FF_1234, 36'h0_8000_0000, p, 1);
        // R8 leaf at level 1
        p[0] = {5'd0, 25'h0, 2'b11};
        run_walk(33'h1_0000_0001, 36'h1_0000_0000, p, 0);
        // R7 invalid at level 1, and non-leaf at level 3
        p[0] = {5'd0, 25'h155, 2'b10};
        run_walk(33'h0_0ABC_DEF0, 36'h0, p, 0);
        p[0] = {5'd0, 25'h3, 2'b01}; p[1] = {5'd0, 25'h5, 2'b01}; p[2] = {5'd0, 25'h7, 2'b01};
        run_walk(33'h0_1111_2222, 36'h0, p, 0);

        for (int i = 0; i < 300; i++) random_walk(i % 6);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule